// File: doc/BRIEF.md
# Programmable master clock divider

This block derives a slower master clock from a fast system clock. Software places a 10-bit divide factor in a shadow register through a plain write port; the divider keeps running on its previous ratio until a separate load strobe copies the shadow value into the active factor. The output is a flop-driven square wave whose period equals the active ratio in input clock cycles.

Some factor codes have a special meaning. Code 0 selects the largest ratio, 1024. Code 1 is not a legal setting and is run as ratio 2, so the output never stalls. With an odd ratio the extra input cycle goes to the low phase. Each load restarts the output at the start of a high phase, so the switch between ratios never produces a runt pulse.

Top module: `mclk_div`

## Requirements
- R1: A cycle with `wr_en_i` high stores `wr_data_i[9:0]` into the shadow factor. From the next cycle `rd_data_o[9:0]` returns the shadow factor, not the active one.
- R2: `wr_data_i[31:10]` is ignored, and `rd_data_o[31:10]` always reads zero.
- R3: A write alone leaves the output ratio unchanged. Only a cycle with `load_i` high copies the shadow factor into the active factor.
- R4: For an even ratio N the output is high for N/2 input cycles, then low for N/2 cycles.
- R5: For an odd ratio N the output is high for (N-1)/2 cycles, then low for (N+1)/2 cycles.
- R6: Active code 0 gives ratio 1024, which is 512 cycles high and 512 cycles low.
- R7: Active code 1 is run as ratio 2, which is 1 cycle high and 1 cycle low.
- R8: After reset the shadow and active factors are 0 and the output is high. The first high phase lasts 512 cycles, counted from the first clock edge after reset release (including the sample before that edge).
- R9: After the clock edge that takes a load, the output is high and stays high for the full high phase of the new ratio, whatever phase it was in before.
- R10: When a write and a load fall in the same cycle, the load takes the shadow value from before that write. The written value stays in the shadow register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the shadow factor |
| wr_data_i | input | 32 | Write word; factor in bits 9:0 |
| load_i | input | 1 | Copies the shadow factor into the active divider |
| rd_data_o | output | 32 | Read word: shadow factor in bits 9:0, zeros above |
| mclk_o | output | 1 | Divided master clock |

## Verification
The assertions assume that `load_i` is the only way the active factor changes, so the phase counter never runs beyond the phase lengths derived from that factor. They also assume that `wr_en_i` and `load_i` are synchronous to `clk_i`. The bench drives both strobes, one cycle wide, on the falling edge, and samples every output on the falling edge. It measures phase lengths either right after a load or from a detected rising edge of `mclk_o`, so each count starts at a known point of the phase.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;
  localparam int unsigned FACTOR_W = 10;
  localparam int unsigned REG_W    = 32;
endpackage

// File: rtl/mclk_div_regs.sv
module mclk_div_regs #(
  parameter int unsigned FW = mclk_div_pkg::FACTOR_W,
  parameter int unsigned RW = mclk_div_pkg::REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_data_i,
  input  logic          load_i,
  output logic [RW-1:0] rd_data_o,
  output logic [FW-1:0] active_o
);
  logic [FW-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en_i) shadow_q <= wr_data_i[FW-1:0];
      if (load_i)  active_q <= shadow_q;   // old shadow wins on a same-cycle write
    end
  end

  assign rd_data_o = {{(RW-FW){1'b0}}, shadow_q};
  assign active_o  = active_q;

  p_wr_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[FW-1:0] == $past(wr_data_i[FW-1:0]));
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[RW-1:FW] == '0);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_o));
  p_load_old_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o == $past(rd_data_o[FW-1:0]));
endmodule

// File: rtl/mclk_div_decode.sv
module mclk_div_decode #(
  parameter int unsigned FW = mclk_div_pkg::FACTOR_W,
  localparam int unsigned CW = FW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] factor_i,
  output logic [CW-1:0] high_len_o,
  output logic [CW-1:0] low_len_o
);
  logic [CW-1:0] ratio;

  always_comb begin
    if (factor_i == '0)      ratio = CW'(1) << FW;
    else if (factor_i == 1)  ratio = CW'(2);   // illegal code runs as 2
    else                     ratio = {1'b0, factor_i};
    high_len_o = ratio >> 1;
    low_len_o  = ratio - high_len_o;             // odd: extra cycle low
  end

  p_split_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_len_o >= 1 && low_len_o >= high_len_o && (low_len_o - high_len_o) <= 1);
  p_zero_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    factor_i == '0 |-> high_len_o + low_len_o == (CW'(1) << FW));
endmodule

// File: rtl/mclk_div_core.sv
module mclk_div_core #(
  parameter int unsigned FW = mclk_div_pkg::FACTOR_W,
  localparam int unsigned CW = FW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [CW-1:0] high_len_i,
  input  logic [CW-1:0] low_len_i,
  output logic          mclk_o
);
  logic [FW-1:0] cnt_q;
  logic          ph_q;
  logic [CW-1:0] cur_len;

  assign cur_len = ph_q ? high_len_i : low_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b1;
      cnt_q <= '0;
    end else if (restart_i) begin
      ph_q  <= 1'b1;
      cnt_q <= '0;
    end else if ({1'b0, cnt_q} == cur_len - 1'b1) begin
      ph_q  <= ~ph_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mclk_o = ph_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < cur_len);
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> mclk_o && cnt_q == '0);
  p_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q && !restart_i && {1'b0, cnt_q} == high_len_i - 1'b1) |=> !mclk_o);
endmodule

// File: rtl/mclk_div.sv
module mclk_div #(
  parameter int unsigned FW = mclk_div_pkg::FACTOR_W,
  parameter int unsigned RW = mclk_div_pkg::REG_W,
  localparam int unsigned CW = FW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_data_i,
  input  logic          load_i,
  output logic [RW-1:0] rd_data_o,
  output logic          mclk_o
);
  logic [FW-1:0] active;
  logic [CW-1:0] high_len, low_len;

  mclk_div_regs #(.FW(FW), .RW(RW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .load_i,
    .rd_data_o, .active_o(active)
  );

  mclk_div_decode #(.FW(FW)) u_dec (
    .clk_i, .rst_ni, .factor_i(active),
    .high_len_o(high_len), .low_len_o(low_len)
  );

  mclk_div_core #(.FW(FW)) u_core (
    .clk_i, .rst_ni, .restart_i(load_i),
    .high_len_i(high_len), .low_len_i(low_len), .mclk_o
  );
endmodule

// File: tb/tb_mclk_div.sv
module tb_mclk_div;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        load_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        mclk_o;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mclk_div dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .load_i, .rd_data_o, .mclk_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  // load now; returns at the first sample after the load edge
  task automatic ld();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic measure(input bit from_rise, output int h, output int l);
    int g = 0;
    if (from_rise) begin
      while (mclk_o !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
      while (mclk_o !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    end
    h = 0; l = 0;
    while (mclk_o === 1'b1 && h < 3000) begin h++; @(negedge clk); end
    while (mclk_o === 1'b0 && l < 3000) begin l++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int h, l;
    chk("R8 reset read", int'(rd_data_o), 0);
    chk("R8 reset mclk", int'(mclk_o), 1);
    measure(1'b0, h, l);
    chk("R8 first high", h, 512);
    chk("R6 reset low", l, 512);
  endtask

  task automatic t_write_no_load();
    int h, l;
    wr(32'hFFFF_FC06);
    chk("R1 read factor", int'(rd_data_o[9:0]), 6);
    chk("R2 reserved zero", int'(rd_data_o[31:10]), 0);
    measure(1'b1, h, l);
    chk("R3 high unchanged", h, 512);
    chk("R3 low unchanged", l, 512);
  endtask

  task automatic t_even();
    int h, l;
    ld();
    chk("R9 high after load", int'(mclk_o), 1);
    measure(1'b0, h, l);
    chk("R4 even high", h, 3);
    chk("R4 even low", l, 3);
  endtask

  task automatic t_odd(input int f);
    int h, l;
    wr(f); ld();
    measure(1'b0, h, l);
    chk("R5 odd high", h, (f - 1) / 2);
    chk("R5 odd low", l, (f + 1) / 2);
  endtask

  task automatic t_code_one();
    int h, l;
    wr(1); ld();
    measure(1'b0, h, l);
    chk("R7 code1 high", h, 1);
    chk("R7 code1 low", l, 1);
    measure(1'b1, h, l);
    chk("R7 code1 steady period", h + l, 2);
  endtask

  task automatic t_code_zero();
    int h, l;
    wr(32'h0000_0400); // only bits 9:0 kept -> 0
    chk("R2 upper bit dropped", int'(rd_data_o), 0);
    ld();
    measure(1'b0, h, l);
    chk("R6 zero high", h, 512);
    chk("R6 zero low", l, 512);
  endtask

  task automatic t_same_cycle();
    int h, l;
    wr(4); ld();
    wr_en_i = 1'b1; wr_data_i = 10; load_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0; load_i = 1'b0;
    chk("R10 shadow keeps new", int'(rd_data_o), 10);
    measure(1'b0, h, l);
    chk("R10 old shadow high", h, 2);
    chk("R10 old shadow low", l, 2);
    ld();
    measure(1'b0, h, l);
    chk("R10 later load high", h, 5);
    chk("R10 later load low", l, 5);
  endtask

  task automatic t_load_mid_low();
    int h, l, g;
    wr(20); ld();
    g = 0;
    while (mclk_o !== 1'b0 && g < 100) begin @(negedge clk); g++; end
    @(negedge clk); @(negedge clk);
    wr(8);
    ld();
    chk("R9 restart high", int'(mclk_o), 1);
    measure(1'b0, h, l);
    chk("R9 full high after load", h, 4);
    chk("R9 low after load", l, 4);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_write_no_load();
    t_even();
    t_odd(7);
    t_odd(1023);
    t_code_one();
    t_code_zero();
    t_same_cycle();
    t_load_mid_low();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule